// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM. A write takes its data one or two clock edges after its address, so read and write cycles can be issued on consecutive clocks with no idle cycle between them. Address, control and byte-lane enables are sampled on the rising clock edge. Write data is sampled on a later rising edge. The array write needs no strobe beyond the clock. The data bus `dq` is bidirectional. The block drives it only in the cycle in which a read returns its data.

Two static inputs set the behaviour. They may change only while reset is asserted. `piped` selects the read path. High gives pipelined mode: read data passes through an output register, and write data arrives two edges after the command. Low gives flow-through mode: the register is bypassed, and write data arrives one edge after the command. `ilv_order` selects how a four-beat burst steps the two low address bits.

The cycle state machine holds one of four states: IDLE, READ, WRITE or SLEEP. The transitions taken at each edge are:
- sleep-entry: to SLEEP whenever `sleep` is high.
- advance: from READ or WRITE back to the same state when `burst_adv` is high.
- stale-advance: from IDLE or SLEEP to IDLE when `burst_adv` is high.
- new-read: to READ when all three selects are active and `wr_n` is high.
- new-write: to WRITE when all three selects are active and `wr_n` is low.
- deselect: to IDLE in every other case.

In pipelined mode a second stage follows the state register. That stage holds the command whose data is on the bus in the current cycle.

Top module: `lw_sram`

## Requirements
- R1: After reset no command is pending, and the block leaves `dq` undriven.
- R2: In flow-through mode, a read issued at edge k drives its data on `dq` during the cycle between edges k and k+1.
- R3: In pipelined mode, a read issued at edge k drives its data on `dq` during the cycle between edges k+1 and k+2.
- R4: Write data for a write issued at edge k is taken from `dq`:
  - at edge k+1 in flow-through mode;
  - at edge k+2 in pipelined mode.
- R5: Reads and writes may be issued on every clock in any mix. A read always returns the latest data written to its address in issue order, including data of a write whose data edge has not yet been reached. The block never drives `dq` in a cycle that carries write data.
- R6: For a write, `lane_wr_n[i]` low stores `dq[9i+8:9i]`. Lanes whose enable is high keep their stored contents. The enables are sampled with the command.
- R7: A new command is taken only when `sel0_n` is low, `sel1` is high and `sel2_n` is low. Otherwise the cycle is deselected:
  - a deselected read does not drive `dq`;
  - a deselected write changes nothing.
- R8: With `ilv_order` low, beat n of a burst (n = 0..3) uses low address bits equal to (start + n) mod 4. The upper address bits are unchanged.
- R9: With `ilv_order` high, beat n uses low address bits equal to start XOR n.
- R10: With `burst_adv` high, the block repeats the previous command type at the next burst address and ignores the selects and `wr_n`. After a deselect or sleep cycle, an advance has no effect.
- R11: With `oe_n` high, `dq` is undriven at once, whatever read is in progress.
- R12: With `sleep` high, `dq` is undriven at once. A command sampled while `sleep` is high is not executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| piped | input | 1 | Static: 1 pipelined, 0 flow-through |
| ilv_order | input | 1 | Static: 1 interleaved burst, 0 linear burst |
| sleep | input | 1 | Asynchronous power-down request |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sel0_n | input | 1 | Select, active low |
| sel1 | input | 1 | Select, active high |
| sel2_n | input | 1 | Select, active low |
| wr_n | input | 1 | 0 write, 1 read for a new command |
| burst_adv | input | 1 | Continue the current burst |
| lane_wr_n | input | LANES | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The assertions assume that `piped` and `ilv_order` change only while reset is held. They also assume that no other agent drives `dq` in a cycle in which the block returns read data. They take `sleep`, `oe_n` and the command inputs to be stable around each rising edge.

The stimulus meets these assumptions in the following ways:
- It sets both mode inputs before releasing reset.
- It drives `dq` only in the data slot computed for each write it issues.
- It changes every input half a cycle away from the rising edge.
- It lets pending reads drain before it raises `sleep`.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Two low address bits step through a four-beat burst.
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SLEEP = 2'd3
    } op_e;

    // Low address bits for a given beat of a burst.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        beat_offset = ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/lw_burst.sv
module lw_burst
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            hi_q    <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            beat_q  <= '0;
        end else if (step) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    assign addr_out = {hi_q, beat_offset(start_q, beat_q, ilv)};

endmodule

// File: rtl/lw_array.sv
module lw_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)
(
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wbe,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_merge.sv
module lw_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)
(
    input  logic [LANES*LANE_W-1:0] base,
    input  logic [LANES*LANE_W-1:0] fresh,
    input  logic [LANES-1:0]        lane_en,
    input  logic                    hit,
    output logic [LANES*LANE_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (hit && lane_en[g]) ?
                                            fresh[g*LANE_W +: LANE_W] :
                                            base[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    piped,
    input  logic                    ilv_order,
    input  logic                    sleep,
    input  logic                    oe_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    wr_n,
    input  logic                    burst_adv,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               op_q;
    op_e               op_nxt;
    op_e               op2_q;
    logic              sel_all;
    logic              take_new;
    logic              take_adv;
    logic [ADDR_W-1:0] addr1;
    logic [ADDR_W-1:0] addr2;
    logic [LANES-1:0]  be1_q;
    logic [LANES-1:0]  be2_q;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] fwd_rd;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] dq_out;
    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_be;
    logic              rd_phase;
    logic              fwd_hit;
    logic              drv_on;

    assign sel_all = !sel0_n && sel1 && !sel2_n;

    // Transition selection: sleep-entry, advance, stale-advance,
    // new-read, new-write, deselect.
    always_comb begin
        op_nxt   = OP_IDLE;
        take_new = 1'b0;
        take_adv = 1'b0;
        if (sleep) begin
            op_nxt = OP_SLEEP;
        end else if (burst_adv) begin
            unique case (op_q)
                OP_READ, OP_WRITE: begin
                    op_nxt   = op_q;
                    take_adv = 1'b1;
                end
                OP_IDLE, OP_SLEEP: begin
                    op_nxt   = OP_IDLE;
                end
            endcase
        end else if (sel_all) begin
            op_nxt   = wr_n ? OP_READ : OP_WRITE;
            take_new = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else begin
            op_q <= op_nxt;
        end
    end

    // Lane enables of stage one, plus the second (late) stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be1_q <= '0;
            op2_q <= OP_IDLE;
            addr2 <= '0;
            be2_q <= '0;
        end else begin
            if (take_new || take_adv) begin
                be1_q <= ~lane_wr_n;
            end
            op2_q <= op_q;
            addr2 <= addr1;
            be2_q <= be1_q;
        end
    end

    lw_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_new),
        .step     (take_adv),
        .ilv      (ilv_order),
        .addr_in  (addr),
        .addr_out (addr1)
    );

    // Output process: retire point, bus phase and forwarding select
    always_comb begin
        if (piped) begin
            rd_phase = (op2_q == OP_READ);
            cm_we    = (op2_q == OP_WRITE);
            cm_addr  = addr2;
            cm_be    = be2_q;
            dq_out   = out_q;
            fwd_hit  = (op2_q == OP_WRITE) && (addr2 == addr1);
        end else begin
            rd_phase = (op_q == OP_READ);
            cm_we    = (op_q == OP_WRITE);
            cm_addr  = addr1;
            cm_be    = be1_q;
            dq_out   = arr_rd;
            fwd_hit  = 1'b0;
        end
        drv_on = rd_phase && !oe_n && !sleep;
    end

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (dq),
        .wbe   (cm_be),
        .raddr (addr1),
        .rdata (arr_rd)
    );

    lw_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .base    (arr_rd),
        .fresh   (dq),
        .lane_en (be2_q),
        .hit     (fwd_hit),
        .merged  (fwd_rd)
    );

    // Pipelined output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (op_q == OP_READ) begin
            out_q <= fwd_rd;
        end
    end

    assign dq = drv_on ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
    import lw_sram_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic piped,
    input logic sleep,
    input logic oe_n,
    input logic sel0_n,
    input logic sel1,
    input logic sel2_n,
    input logic burst_adv,
    input op_e  op_q,
    input op_e  op2_q,
    input logic drv_on
);
    // R12
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (op_q == OP_SLEEP));

    // R7
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !burst_adv && (sel0_n || !sel1 || sel2_n)) |=> (op_q == OP_IDLE));

    // R10
    adv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && burst_adv && (op_q == OP_READ || op_q == OP_WRITE)) |=> (op_q == $past(op_q)));

    // R10
    adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && burst_adv && (op_q == OP_IDLE || op_q == OP_SLEEP)) |=> (op_q == OP_IDLE));

    // R3
    pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (piped && op_q == OP_READ) |=> (oe_n || sleep || drv_on));

    // R5
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_on |-> !(piped ? (op2_q == OP_WRITE) : (op_q == OP_WRITE)));

endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .piped     (piped),
    .sleep     (sleep),
    .oe_n      (oe_n),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .sel2_n    (sel2_n),
    .burst_adv (burst_adv),
    .op_q      (op_q),
    .op2_q     (op2_q),
    .drv_on    (drv_on)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
    localparam int AW = 8;
    localparam int LN = 2;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam logic [DW-1:0] FLOAT = '1;   // pulled-up idle bus

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, piped, ilv_order, sleep, oe_n, sel0_n, sel1, sel2_n, wr_n, burst_adv;
    logic [LN-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    wire  [DW-1:0] dq;
    logic          tb_en;
    logic [DW-1:0] tb_d;

    assign dq = tb_en ? tb_d : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dq[i]);
    end

    lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .piped(piped), .ilv_order(ilv_order),
        .sleep(sleep), .oe_n(oe_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .wr_n(wr_n), .burst_adv(burst_adv), .lane_wr_n(lane_wr_n), .addr(addr), .dq(dq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int            due;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb[$];

    typedef enum {K_NOP, K_RD, K_WR, K_ADV} kind_e;

    logic [DW-1:0] ref_mem [1 << AW];
    logic [DW-1:0] ws_d [8];
    bit            ws_v [8];
    kind_e         last_k;
    logic [AW-1:0] b_base;
    logic [1:0]    b_cnt;
    bit            b_live;
    bit            oe_v, slp_v, force_z;
    int            kill;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read items when their data cycle arrives
    always @(negedge clk) begin
        item_t it;
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            if (it.due < cyc) check(1'b0, {it.tag, " missed"}, dq, it.exp);
            else              check(dq === it.exp, it.tag, dq, it.exp);
        end
    end

    // Driver: one call per clock cycle
    task automatic step(input kind_e k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [LN-1:0] bwn, input string tag);
        int            kc;
        int            slot;
        logic [AW-1:0] ea;
        kind_e         ek;
        bit            eff;
        item_t         it;
        @(negedge clk);
        kc = cyc + 1;
        oe_n  = oe_v;
        sleep = slp_v;
        tb_en = ws_v[cyc % 8];
        tb_d  = ws_d[cyc % 8];
        ws_v[cyc % 8] = 0;
        wr_n = 1'b1; burst_adv = 1'b0; sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
        lane_wr_n = bwn; addr = a;
        eff = 0; ek = k; ea = a;
        if (k == K_RD || k == K_WR) begin
            sel0_n = (kill == 1);
            sel1   = (kill != 2);
            sel2_n = (kill == 3);
            wr_n   = (k != K_WR);
            eff    = (kill == 0) && !slp_v;
            if (eff) begin b_live = 1; last_k = k; b_base = a; b_cnt = 0; end
            else b_live = 0;
        end else if (k == K_ADV) begin
            burst_adv = 1'b1;
            if (b_live && !slp_v) begin
                eff = 1; ek = last_k; b_cnt = b_cnt + 2'd1;
                ea = {b_base[AW-1:2], ilv_order ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            end else b_live = 0;
        end else begin
            b_live = 0;
        end
        if (slp_v) b_live = 0;
        if (eff && ek == K_WR) begin
            slot = piped ? kc + 1 : kc;
            ws_v[slot % 8] = 1;
            ws_d[slot % 8] = d;
            for (int i = 0; i < LN; i++) if (!bwn[i]) ref_mem[ea][i*LW +: LW] = d[i*LW +: LW];
        end
        it.due = piped ? kc + 1 : kc;
        it.tag = tag;
        if (eff && ek == K_RD) begin
            it.exp = force_z ? FLOAT : ref_mem[ea];
            sb.push_back(it);
        end else if (!eff && (k == K_RD || k == K_ADV)) begin
            it.exp = FLOAT;
            sb.push_back(it);
        end
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(K_NOP, '0, '0, '1, "");
    endtask

    task automatic run(input bit pm);
        string lat, bst;
        lat = pm ? "R3 pipelined read" : "R2 flow-through read";
        bst = pm ? "R9 interleaved burst" : "R8 linear burst";
        rst_n = 1'b0; piped = pm; ilv_order = pm;
        oe_v = 0; slp_v = 0; force_z = 0; kill = 0; b_live = 0;
        tb_en = 0; sleep = 0; oe_n = 0; burst_adv = 0; sel0_n = 1; sel1 = 0; sel2_n = 1;
        for (int i = 0; i < 8; i++) ws_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(dq === FLOAT, "R1 bus idle after reset", dq, FLOAT);
        // R4 late writes, back to back
        step(K_WR, 8'h10, 18'h01234, 2'b00, "");
        step(K_WR, 8'h11, 18'h05678, 2'b00, "");
        step(K_WR, 8'h12, 18'h09ABC, 2'b00, "");
        step(K_WR, 8'h13, 18'h0DEF0, 2'b00, "");
        step(K_RD, 8'h10, '0, '1, lat);
        // R5 read-after-write with no gap
        step(K_WR, 8'h20, 18'h1A5A5, 2'b00, "");
        step(K_RD, 8'h20, '0, '1, "R5 read after write");
        step(K_RD, 8'h11, '0, '1, "R4 late write data");
        step(K_WR, 8'h21, 18'h2C3C3, 2'b00, "");
        step(K_RD, 8'h21, '0, '1, "R5 forwarded");
        // R6 byte lanes: lane 1 only
        step(K_WR, 8'h20, 18'h3F00F, 2'b01, "");
        step(K_RD, 8'h20, '0, '1, "R6 lane merge");
        // burst read from start offset 1
        step(K_RD,  8'h11, '0, '1, bst);
        step(K_ADV, 8'h00, '0, '1, bst);
        step(K_ADV, 8'h00, '0, '1, bst);
        step(K_ADV, 8'h00, '0, '1, bst);
        // burst write from start offset 2, read back singly
        step(K_WR,  8'h32, 18'h00111, 2'b00, "");
        step(K_ADV, 8'h00, 18'h00222, 2'b00, "");
        step(K_ADV, 8'h00, 18'h00333, 2'b00, "");
        step(K_ADV, 8'h00, 18'h00444, 2'b00, "");
        for (int i = 0; i < 4; i++) step(K_RD, 8'h30 + 8'(i), '0, '1, bst);
        nops(2);
        // R7 selects, R10 stale advance
        kill = 2; step(K_WR, 8'h10, 18'h07777, 2'b00, "");
        kill = 1; step(K_RD, 8'h11, '0, '1, "R7 sel0 off");
        kill = 3; step(K_RD, 8'h11, '0, '1, "R7 sel2 off");
        kill = 0;
        step(K_ADV, 8'h00, '0, '1, "R10 advance after deselect");
        step(K_RD, 8'h10, '0, '1, "R7 deselected write ignored");
        nops(3);
        // R11 output enable
        oe_v = 1; force_z = 1;
        step(K_RD, 8'h12, '0, '1, "R11 oe high");
        force_z = 0;
        nops(2);
        oe_v = 0;
        step(K_RD, 8'h12, '0, '1, "R11 oe restored");
        nops(2);
        // R12 sleep
        slp_v = 1;
        step(K_WR, 8'h13, 18'h06666, 2'b00, "");
        step(K_RD, 8'h13, '0, '1, "R12 read in sleep");
        nops(1);
        slp_v = 0;
        nops(1);
        step(K_RD, 8'h13, '0, '1, "R12 write in sleep ignored");
        nops(4);
    endtask

    initial begin
        run(1'b0);
        run(1'b1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule